// File: doc/BRIEF.md
# Parallel NOR Flash Identification Sequencer

This block runs the software identification exchange with a byte-wide parallel NOR flash. After a `start` pulse it waits an entry settling time, puts the device into read-array mode, and sends the three-write unlock that switches it into identification mode. It then reads the manufacturer and device codes. Any code byte equal to 0x7F is extended by one continuation byte.

The block then leaves identification mode with the same reset sequence and reads the same locations again. If a second read returns the same code, the device most likely never switched modes, and the block flags this. The codes it captured are compared with expected values, and the parity of the manufacturer's final byte is checked.

Static inputs set the following:
- the unlock address mask;
- whether the two unlock addresses swap and the identification offsets double;
- whether every reset is preceded by the two unlock writes;
- the timing profile.

All bus traffic is single-cycle. A write is one `busWrEn` cycle. A read is one `busRdEn` cycle, and `busRdData` is captured at the closing edge of that cycle. Configuration and expected codes must be held stable while `busy` is high.

Top module: `flash_id_probe`

## Requirements
- R1: An unlock is 0xAA written to the command address, then 0x55 to the alternate address, then the command byte to the command address. The command address is 0x5555 and the alternate address is 0x2AAA; when `cfgShifted` is 1 the two are swapped.
- R2: Both unlock addresses are ANDed with the mask that `cfgMaskSel` picks: 1 selects 0x07FF, 2 selects 0x0FFF, and 0 or 3 selects 0xFFFF.
- R3: A reset writes 0xF0 to the command address. When `cfgLongReset` is 1, the 0xAA and 0x55 unlock writes come first. One probe therefore issues 5 writes in short mode and 9 writes in long mode.
- R4: Identification mode is entered with command 0x90. The manufacturer byte is then read at address 0 and the device byte at address 1, or at address 2 when `cfgShifted` is 1.
- R5: A first code byte of 0x7F is shifted up by 8 bits and followed by a byte read at 0x0100 (manufacturer) or 0x0101 (device). Otherwise the code is the single byte, zero-extended to 16 bits.
- R6: After the exit reset the same locations are read again, with the same continuation rule. `mfrStale` is set if the re-read manufacturer code equals the captured one, and `devStale` likewise for the device code.
- R7: `parityErr` is 1 when the last manufacturer byte read in identification mode has an even number of ones.
- R8: `match` is 1 only when both 16-bit captured codes equal `expMfr` and `expDev`.
- R9: The entry delay E and exit delay X depend on `cfgTiming`:
  - 0 gives E = X = 0.
  - 1 gives E = 10000 us and X = 40 us.
  - 2 or 3 gives E = X = `cfgProbeUs` us.
  - Delays are counted as microseconds times `CYC_PER_US` clock cycles.
  - E is waited before the first reset and after the 0x90 write. X is waited after every 0xF0 write.
  - A 10 us gap follows each unlock write of an entry when E is nonzero, and each unlock write of a reset when X is nonzero.
- R10: `start` is ignored while `busy` is high. `done` rises when the probe ends and, together with all results, holds until the next `start`. A read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (single-cycle pulse) |
| cfgMaskSel | input | 2 | Unlock address mask select |
| cfgShifted | input | 1 | Swapped unlock addresses, doubled ID offsets |
| cfgLongReset | input | 1 | Precede each reset by the two unlock writes |
| cfgTiming | input | 2 | Delay profile: zero, default, custom |
| cfgProbeUs | input | 16 | Custom entry/exit delay in microseconds |
| expMfr | input | 16 | Expected extended manufacturer code |
| expDev | input | 16 | Expected extended device code |
| busWrEn | output | 1 | Write strobe to the flash |
| busRdEn | output | 1 | Read strobe to the flash |
| busAddr | output | ADDR_W | Flash byte address |
| busWrData | output | 8 | Write data byte |
| busRdData | input | 8 | Read data byte, sampled when busRdEn is high |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Probe finished, results valid |
| mfrId | output | 16 | Captured manufacturer code |
| devId | output | 16 | Captured device code |
| match | output | 1 | Both codes equal the expected values |
| parityErr | output | 1 | Manufacturer byte has even parity |
| mfrStale | output | 1 | Manufacturer code unchanged after exit |
| devStale | output | 1 | Device code unchanged after exit |

## Verification
Some properties are checked on every cycle:
- Each 0x55 write directly follows a 0xAA write, and each 0x90 write directly follows a 0x55 write.
- A continuation read happens only when the first byte of that code was 0x7F.
- Reads and writes never collide.
- Results do not move while `done` holds.
- The parity flag always agrees with the reported manufacturer code.

Other behaviour can only be shown by the bench's scenarios, which run against a behavioural flash model that enters identification mode only on a correctly addressed unlock. These scenarios cover the masked and shifted addresses, the write counts of short and long resets, the delay lengths and gaps, the continuation codes, the stale flags from a device that never changes mode, and a `start` sent mid-probe.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [2:0] {
    SEL_CMD, SEL_ALT, SEL_ID0, SEL_ID1, SEL_CONT0, SEL_CONT1
  } addrSel_e;

  typedef enum logic [1:0] {
    DST_MFR, DST_DEV, DST_MFR_EXT, DST_DEV_EXT
  } rdDst_e;

  typedef struct packed {
    logic     wrEn;
    logic [7:0] wrData;
    logic     rdEn;
    addrSel_e addrSel;
    rdDst_e   rdDst;
    logic     pass2;
    logic     clear;
    logic     finish;
  } ctrl_t;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_IDENTIFY = 8'h90;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CONT_CODE = 8'h7F;

endpackage

// File: rtl/probe_control.sv
module probe_control
  import flash_probe_pkg::*;
#(
  parameter int CYC_PER_US   = 10,
  parameter int DEF_ENTER_US = 10000,
  parameter int DEF_EXIT_US  = 40,
  parameter int GAP_US       = 10,
  parameter int TW           = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cfgLongReset,
  input  logic [1:0]  cfgTiming,
  input  logic [15:0] cfgProbeUs,
  input  logic        mfrCont,
  input  logic        devCont,
  output ctrl_t       ctrl,
  output logic        busy,
  output logic        done
);

  localparam logic [TW-1:0] GAP_CYC   = TW'(GAP_US * CYC_PER_US);
  localparam logic [TW-1:0] ENTER_CYC = TW'(DEF_ENTER_US * CYC_PER_US);
  localparam logic [TW-1:0] EXIT_CYC  = TW'(DEF_EXIT_US * CYC_PER_US);

  typedef enum logic [4:0] {
    S_IDLE, S_PRE, S_RAA, S_RAAG, S_R55, S_R55G, S_RF0, S_RWT,
    S_EAA, S_EAAG, S_E55, S_E55G, S_E90, S_EWT,
    S_RDM, S_RDD, S_RSEL, S_RMC, S_RDC, S_PEND
  } state_e;

  state_e state;
  state_e resetHead;
  state_e afterReset;
  logic [TW-1:0] timer;
  logic [TW-1:0] enterCyc;
  logic [TW-1:0] exitCyc;
  logic pass2;
  logic timerDone;

  always_comb begin
    case (cfgTiming)
      2'd0: begin enterCyc = '0; exitCyc = '0; end
      2'd1: begin enterCyc = ENTER_CYC; exitCyc = EXIT_CYC; end
      default: begin
        enterCyc = TW'(cfgProbeUs) * TW'(CYC_PER_US);
        exitCyc  = enterCyc;
      end
    endcase
  end

  assign resetHead  = cfgLongReset ? S_RAA : S_RF0;
  assign afterReset = pass2 ? S_RDM : S_EAA;
  assign timerDone  = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
      pass2 <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pass2 <= 1'b0;
          done  <= 1'b0;
          if (enterCyc != '0) begin state <= S_PRE; timer <= enterCyc - 1'b1; end
          else state <= resetHead;
        end
        S_PRE:  if (timerDone) state <= resetHead; else timer <= timer - 1'b1;
        S_RAA:  if (exitCyc != '0) begin state <= S_RAAG; timer <= GAP_CYC - 1'b1; end
                else state <= S_R55;
        S_RAAG: if (timerDone) state <= S_R55; else timer <= timer - 1'b1;
        S_R55:  if (exitCyc != '0) begin state <= S_R55G; timer <= GAP_CYC - 1'b1; end
                else state <= S_RF0;
        S_R55G: if (timerDone) state <= S_RF0; else timer <= timer - 1'b1;
        S_RF0:  if (exitCyc != '0) begin state <= S_RWT; timer <= exitCyc - 1'b1; end
                else state <= afterReset;
        S_RWT:  if (timerDone) state <= afterReset; else timer <= timer - 1'b1;
        S_EAA:  if (enterCyc != '0) begin state <= S_EAAG; timer <= GAP_CYC - 1'b1; end
                else state <= S_E55;
        S_EAAG: if (timerDone) state <= S_E55; else timer <= timer - 1'b1;
        S_E55:  if (enterCyc != '0) begin state <= S_E55G; timer <= GAP_CYC - 1'b1; end
                else state <= S_E90;
        S_E55G: if (timerDone) state <= S_E90; else timer <= timer - 1'b1;
        S_E90:  if (enterCyc != '0) begin state <= S_EWT; timer <= enterCyc - 1'b1; end
                else state <= S_RDM;
        S_EWT:  if (timerDone) state <= S_RDM; else timer <= timer - 1'b1;
        S_RDM:  state <= S_RDD;
        S_RDD:  state <= S_RSEL;
        S_RSEL: state <= mfrCont ? S_RMC : (devCont ? S_RDC : S_PEND);
        S_RMC:  state <= devCont ? S_RDC : S_PEND;
        S_RDC:  state <= S_PEND;
        S_PEND: if (!pass2) begin
          pass2 <= 1'b1;
          state <= resetHead;
        end else begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl        = '0;
    ctrl.pass2  = pass2;
    ctrl.clear  = (state == S_IDLE) && start;
    ctrl.finish = (state == S_PEND) && pass2;
    case (state)
      S_RAA, S_EAA: begin ctrl.wrEn = 1'b1; ctrl.wrData = CMD_UNLOCK1; ctrl.addrSel = SEL_CMD; end
      S_R55, S_E55: begin ctrl.wrEn = 1'b1; ctrl.wrData = CMD_UNLOCK2; ctrl.addrSel = SEL_ALT; end
      S_RF0:  begin ctrl.wrEn = 1'b1; ctrl.wrData = CMD_RESET;    ctrl.addrSel = SEL_CMD; end
      S_E90:  begin ctrl.wrEn = 1'b1; ctrl.wrData = CMD_IDENTIFY; ctrl.addrSel = SEL_CMD; end
      S_RDM:  begin ctrl.rdEn = 1'b1; ctrl.addrSel = SEL_ID0;   ctrl.rdDst = DST_MFR; end
      S_RDD:  begin ctrl.rdEn = 1'b1; ctrl.addrSel = SEL_ID1;   ctrl.rdDst = DST_DEV; end
      S_RMC:  begin ctrl.rdEn = 1'b1; ctrl.addrSel = SEL_CONT0; ctrl.rdDst = DST_MFR_EXT; end
      S_RDC:  begin ctrl.rdEn = 1'b1; ctrl.addrSel = SEL_CONT1; ctrl.rdDst = DST_DEV_EXT; end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE);

  // Last byte written, kept for the ordering checks below.
  logic [7:0] prevWr;
  always_ff @(posedge clk) begin
    if (!rstN) prevWr <= '0;
    else if (ctrl.wrEn) prevWr <= ctrl.wrData;
  end

  a_r1_unlock_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrEn && ctrl.wrData == CMD_UNLOCK2) |-> prevWr == CMD_UNLOCK1);

  a_r1_command_order: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrEn && ctrl.wrData == CMD_IDENTIFY) |-> prevWr == CMD_UNLOCK2);

endmodule

// File: rtl/probe_datapath.sv
module probe_datapath
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [1:0]        cfgMaskSel,
  input  logic              cfgShifted,
  input  logic [7:0]        busRdData,
  input  logic [ID_W-1:0]   expMfr,
  input  logic [ID_W-1:0]   expDev,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  output logic              mfrCont,
  output logic              devCont,
  output logic [ID_W-1:0]   mfrId,
  output logic [ID_W-1:0]   devId,
  output logic              match,
  output logic              parityErr,
  output logic              mfrStale,
  output logic              devStale
);

  localparam logic [ADDR_W-1:0] ADR_HI   = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] ADR_LO   = ADDR_W'(16'h2AAA);
  localparam logic [ADDR_W-1:0] ADR_EXTM = ADDR_W'(16'h0100);
  localparam logic [ADDR_W-1:0] ADR_EXTD = ADDR_W'(16'h0101);

  logic [ADDR_W-1:0] mask, cmdAddr, altAddr;
  logic [ID_W-1:0] idMfr, idDev, chkMfr, chkDev, curMfr, curDev;

  always_comb begin
    case (cfgMaskSel)
      2'd1:    mask = ADDR_W'(16'h07FF);
      2'd2:    mask = ADDR_W'(16'h0FFF);
      default: mask = '1;
    endcase
  end

  assign cmdAddr = (cfgShifted ? ADR_LO : ADR_HI) & mask;
  assign altAddr = (cfgShifted ? ADR_HI : ADR_LO) & mask;

  always_comb begin
    case (ctrl.addrSel)
      SEL_CMD:   busAddr = cmdAddr;
      SEL_ALT:   busAddr = altAddr;
      SEL_ID1:   busAddr = cfgShifted ? ADDR_W'(2) : ADDR_W'(1);
      SEL_CONT0: busAddr = ADR_EXTM;
      SEL_CONT1: busAddr = ADR_EXTD;
      default:   busAddr = '0;
    endcase
  end

  assign busWrEn   = ctrl.wrEn;
  assign busRdEn   = ctrl.rdEn;
  assign busWrData = ctrl.wrData;

  assign curMfr  = ctrl.pass2 ? chkMfr : idMfr;
  assign curDev  = ctrl.pass2 ? chkDev : idDev;
  assign mfrCont = (curMfr[7:0] == CONT_CODE);
  assign devCont = (curDev[7:0] == CONT_CODE);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      idMfr  <= '0;
      idDev  <= '0;
      chkMfr <= '0;
      chkDev <= '0;
    end else if (ctrl.rdEn) begin
      case (ctrl.rdDst)
        DST_MFR:
          if (ctrl.pass2) chkMfr <= ID_W'(busRdData);
          else            idMfr  <= ID_W'(busRdData);
        DST_DEV:
          if (ctrl.pass2) chkDev <= ID_W'(busRdData);
          else            idDev  <= ID_W'(busRdData);
        DST_MFR_EXT:
          if (ctrl.pass2) chkMfr <= {chkMfr[ID_W-9:0], busRdData};
          else            idMfr  <= {idMfr[ID_W-9:0], busRdData};
        default:
          if (ctrl.pass2) chkDev <= {chkDev[ID_W-9:0], busRdData};
          else            idDev  <= {idDev[ID_W-9:0], busRdData};
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      mfrId     <= '0;
      devId     <= '0;
      match     <= 1'b0;
      parityErr <= 1'b0;
      mfrStale  <= 1'b0;
      devStale  <= 1'b0;
    end else if (ctrl.finish) begin
      mfrId     <= idMfr;
      devId     <= idDev;
      match     <= (idMfr == expMfr) && (idDev == expDev);
      parityErr <= ~(^idMfr[7:0]);
      mfrStale  <= (idMfr == chkMfr);
      devStale  <= (idDev == chkDev);
    end
  end

  a_r5_cont_gate: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.rdEn && ctrl.rdDst == DST_MFR_EXT) |-> curMfr[7:0] == CONT_CODE);

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int CYC_PER_US   = 10,
  parameter int DEF_ENTER_US = 10000,
  parameter int DEF_EXIT_US  = 40,
  parameter int GAP_US       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cfgMaskSel,
  input  logic              cfgShifted,
  input  logic              cfgLongReset,
  input  logic [1:0]        cfgTiming,
  input  logic [15:0]       cfgProbeUs,
  input  logic [15:0]       expMfr,
  input  logic [15:0]       expDev,
  output logic              busWrEn,
  output logic              busRdEn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWrData,
  input  logic [7:0]        busRdData,
  output logic              busy,
  output logic              done,
  output logic [15:0]       mfrId,
  output logic [15:0]       devId,
  output logic              match,
  output logic              parityErr,
  output logic              mfrStale,
  output logic              devStale
);

  ctrl_t ctrl;
  logic mfrCont, devCont;

  probe_control #(
    .CYC_PER_US(CYC_PER_US), .DEF_ENTER_US(DEF_ENTER_US),
    .DEF_EXIT_US(DEF_EXIT_US), .GAP_US(GAP_US), .TW(32)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLongReset(cfgLongReset),
    .cfgTiming(cfgTiming), .cfgProbeUs(cfgProbeUs), .mfrCont(mfrCont),
    .devCont(devCont), .ctrl(ctrl), .busy(busy), .done(done)
  );

  probe_datapath #(.ADDR_W(ADDR_W), .ID_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgMaskSel(cfgMaskSel),
    .cfgShifted(cfgShifted), .busRdData(busRdData), .expMfr(expMfr),
    .expDev(expDev), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .mfrCont(mfrCont), .devCont(devCont),
    .mfrId(mfrId), .devId(devId), .match(match), .parityErr(parityErr),
    .mfrStale(mfrStale), .devStale(devStale)
  );

  a_r10_one_op: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(mfrId) && $stable(devId) && $stable(match)
                          && $stable(mfrStale) && $stable(devStale) && done));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (parityErr == ~(^mfrId[7:0])));

endmodule

// File: tb/flash_id_probe_test.sv
module flash_id_probe_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0] cfgMaskSel = '0, cfgTiming = '0;
  logic cfgShifted = 1'b0, cfgLongReset = 1'b0;
  logic [15:0] cfgProbeUs = '0, expMfr = '0, expDev = '0;
  logic busWrEn, busRdEn, busy, done, match, parityErr, mfrStale, devStale;
  logic [15:0] busAddr, mfrId, devId;
  logic [7:0] busWrData, busRdData;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_id_probe #(.ADDR_W(16), .CYC_PER_US(CPU)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgMaskSel(cfgMaskSel),
    .cfgShifted(cfgShifted), .cfgLongReset(cfgLongReset), .cfgTiming(cfgTiming),
    .cfgProbeUs(cfgProbeUs), .expMfr(expMfr), .expDev(expDev),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busy(busy), .done(done),
    .mfrId(mfrId), .devId(devId), .match(match), .parityErr(parityErr),
    .mfrStale(mfrStale), .devStale(devStale)
  );

  // Behavioural flash model
  logic [7:0] m0, d0, mExt, dExt;
  logic deaf = 1'b0, clrModel = 1'b0, idMode;
  logic [1:0] seq;
  int writes, minGap, cyc, aaCyc;
  logic [15:0] maskVal, addrA, addrB, addrId1;

  always_comb begin
    case (cfgMaskSel)
      2'd1: maskVal = 16'h07FF;
      2'd2: maskVal = 16'h0FFF;
      default: maskVal = 16'hFFFF;
    endcase
    addrA = (cfgShifted ? 16'h2AAA : 16'h5555) & maskVal;
    addrB = (cfgShifted ? 16'h5555 : 16'h2AAA) & maskVal;
    addrId1 = cfgShifted ? 16'h0002 : 16'h0001;
  end

  always_comb begin
    if (!idMode) busRdData = busAddr[7:0] ^ 8'h3C;
    else if (busAddr == 16'h0000) busRdData = m0;
    else if (busAddr == addrId1) busRdData = d0;
    else if (busAddr == 16'h0100) busRdData = mExt;
    else if (busAddr == 16'h0101) busRdData = dExt;
    else busRdData = 8'hFF;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rstN || clrModel) begin
      idMode <= 1'b0; seq <= 2'd0; writes <= 0; minGap <= 1000000; aaCyc <= 0;
    end else if (busWrEn) begin
      writes <= writes + 1;
      if (busWrData == 8'hAA && busAddr == addrA) begin
        seq <= 2'd1; aaCyc <= cyc;
      end else if (busWrData == 8'h55 && busAddr == addrB && seq == 2'd1) begin
        seq <= 2'd2;
        if (cyc - aaCyc < minGap) minGap <= cyc - aaCyc;
      end else if (busWrData == 8'h90 && busAddr == addrA && seq == 2'd2) begin
        seq <= 2'd0;
        if (!deaf) idMode <= 1'b1;
      end else if (busWrData == 8'hF0 && busAddr == addrA) begin
        seq <= 2'd0; idMode <= 1'b0;
      end else seq <= 2'd0;
    end
  end

  initial cyc = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkTrue(input string req, input string what, input bit cond, input int act);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d outside expected range", req, what, act);
    end
  endtask

  // Runs one probe; returns the cycle count from start to done.
  task automatic runProbe(input logic [1:0] msel, input logic sh, input logic lr,
                          input logic [1:0] tm, input logic [15:0] us,
                          input logic [15:0] eM, input logic [15:0] eD,
                          input bit midStart, output int cycles);
    @(negedge clk);
    cfgMaskSel = msel; cfgShifted = sh; cfgLongReset = lr; cfgTiming = tm;
    cfgProbeUs = us; expMfr = eM; expDev = eD; clrModel = 1'b1;
    @(negedge clk);
    clrModel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    if (midStart) begin
      repeat (3) @(negedge clk);
      cycles += 3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    while (!done && cycles < 150000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic testReset();
    check("R10", "busy after reset", busy, 0);
    check("R10", "done after reset", done, 0);
    check("R10", "bus idle after reset", {busWrEn, busRdEn}, 0);
  endtask

  task automatic testBasic();
    int c;
    m0 = 8'h01; d0 = 8'hA4; mExt = 8'h00; dExt = 8'h00; deaf = 1'b0;
    runProbe(2'd0, 1'b0, 1'b0, 2'd0, 16'd0, 16'h0001, 16'h00A4, 1'b0, c);
    check("R4", "mfrId plain", mfrId, 16'h0001);
    check("R4", "devId plain", devId, 16'h00A4);
    check("R8", "match plain", match, 1);
    check("R7", "parity odd byte", parityErr, 0);
    check("R6", "stale flags entered", {mfrStale, devStale}, 0);
    check("R3", "short reset write count", writes, 5);
    checkTrue("R9", "zero-delay duration", c < 30, c);
    check("R10", "busy low when done", busy, 0);
  endtask

  task automatic testShiftedLong();
    int c;
    m0 = 8'h7F; d0 = 8'h5B; mExt = 8'h9D; dExt = 8'h11; deaf = 1'b0;
    runProbe(2'd2, 1'b1, 1'b1, 2'd2, 16'd3, 16'h7F9D, 16'h005B, 1'b0, c);
    check("R5", "mfr continuation", mfrId, 16'h7F9D);
    check("R4", "shifted device offset", devId, 16'h005B);
    check("R2", "masked shifted match", match, 1);
    check("R3", "long reset write count", writes, 9);
    checkTrue("R9", "custom unlock gap", minGap >= 10 * CPU, minGap);
    checkTrue("R9", "custom delay duration", c >= 4 * 3 * CPU, c);
  endtask

  task automatic testDevContMismatch();
    int c;
    m0 = 8'h03; d0 = 8'h7F; mExt = 8'h00; dExt = 8'h20; deaf = 1'b0;
    runProbe(2'd1, 1'b0, 1'b0, 2'd0, 16'd0, 16'h0003, 16'h7F21, 1'b0, c);
    check("R5", "dev continuation", devId, 16'h7F20);
    check("R8", "mismatch on device", match, 0);
    check("R7", "even parity flagged", parityErr, 1);
    check("R2", "7FF mask ID entry", mfrId, 16'h0003);
    checkTrue("R1", "back-to-back unlock", minGap == 1, minGap);
  endtask

  task automatic testDeaf();
    int c;
    deaf = 1'b1;
    runProbe(2'd0, 1'b0, 1'b0, 2'd0, 16'd0, 16'h0001, 16'h00A4, 1'b0, c);
    check("R6", "mfr stale", mfrStale, 1);
    check("R6", "dev stale", devStale, 1);
    check("R6", "array content read", {mfrId, devId}, {16'h003C, 16'h003D});
    check("R8", "no match deaf", match, 0);
    deaf = 1'b0;
  endtask

  task automatic testDefaultTiming();
    int c;
    m0 = 8'h01; d0 = 8'hA4; deaf = 1'b0;
    runProbe(2'd0, 1'b0, 1'b0, 2'd1, 16'd0, 16'h0001, 16'h00A4, 1'b0, c);
    checkTrue("R9", "default delay duration", c >= 2 * 10000 * CPU + 2 * 40 * CPU, c);
    checkTrue("R9", "default entry gap", minGap >= 10 * CPU, minGap);
    check("R8", "match default timing", match, 1);
  endtask

  task automatic testStartWhileBusy();
    int c;
    m0 = 8'h01; d0 = 8'hA4; deaf = 1'b0;
    runProbe(2'd0, 1'b0, 1'b0, 2'd0, 16'd0, 16'h0001, 16'h00A4, 1'b1, c);
    check("R10", "mid-run start ignored writes", writes, 5);
    check("R10", "mid-run start result", match, 1);
    repeat (3) @(negedge clk);
    check("R10", "done holds", done, 1);
    check("R10", "result holds", devId, 16'h00A4);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testShiftedLong();
    testDevContMismatch();
    testDeaf();
    testStartWhileBusy();
    testDefaultTiming();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule